// File: doc/BRIEF.md
# I2C Target Byte Engine with 7-bit and 10-bit Address Filtering

This block is the target side of an I2C link. It oversamples SCL and SDA with the system clock, finds START and STOP conditions, and moves bytes to and from one shared data register. The block compares incoming address bytes with a strapped own address, in either 7-bit or 10-bit form. It pulls SDA low in the acknowledge slot only when the transfer is meant for it. Transfers meant for other targets are passed over without a trace.

Software sees three byte-wide registers on a simple CPU port: control, data and status. Every completed byte raises one interrupt, and address bytes count as bytes. The interrupt stays high until software clears it in the status register. When the block transmits, software loads the data register and sets a GO bit before each byte. The block never holds SCL low, so software must do this during the high phase of the acknowledge clock.

Top module: `i2c_tgt_top`

## Requirements
- R1: In 7-bit mode (CTRL bit1 = 0), an address byte whose bits [7:1] equal own_addr[6:0] is acknowledged: sda_pull is high during the ninth SCL clock. The byte also sets irq (STAT bit0), sets STAT bit1 (address byte) and is placed in DATA.
- R2: Each data byte of an accepted write transfer is acknowledged, raises irq and is placed in DATA, with STAT bit1 = 0.
- R3: In 7-bit mode, a non-matching address byte is not acknowledged and raises no irq. No later byte of the same transfer is acknowledged or raises irq, and DATA keeps its previous value.
- R4: In 10-bit mode (CTRL bit1 = 1), a first byte equal to 11110, own_addr[9:8], R/W is acknowledged and raises irq. A following second byte equal to own_addr[7:0] is also acknowledged and raises irq, with STAT bit1 = 1.
- R5: In 10-bit mode, when the first byte matches and the second byte differs from own_addr[7:0], the second byte is not acknowledged. It still raises irq and sets STAT bit2 (receive abort), and the rest of the transfer is ignored.
- R6: In 10-bit mode, a first byte whose upper bits do not match is not acknowledged and raises no irq.
- R7: When a byte is captured while STAT bit6 (DATA not yet read) is set, STAT bit4 (overrun) is set and DATA takes the new byte.
- R8: An accepted address with R/W = 1 enters transmit. Each byte is sent MSB first from DATA only if CTRL bit0 (GO) was set before the SCL fall that starts the byte. GO then clears. Without GO the byte is sent as all ones.
- R9: After each transmitted byte, irq is raised at the master's acknowledge clock.
- R10: A master NACK on a transmitted byte sets STAT bit3 (transmit abort). After it the block releases SDA and raises no irq for the rest of the transfer.
- R11: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. A repeated START (SDA falling while SCL is high) restarts address matching.
- R12: CPU map: address 0 = CTRL, 1 = DATA (a read clears STAT bit6), 2 = STAT. Writing 1 to STAT bits 0, 2, 3 or 4 clears them. irq equals STAT bit0. After reset CTRL, DATA and STAT read 0 and sda_pull is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | High to pull SDA low (open-drain enable) |
| own_addr | input | 10 | Own target address; 7-bit mode uses bits [6:0] |
| cpu_en | input | 1 | CPU access strobe, one clock per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while cpu_en is high |
| irq | output | 1 | Byte-complete interrupt |

## Verification
The bench builds the block with three synchronizer stages instead of the default two, so each bus edge reaches the byte engine one clock later. This shows that acknowledge and transmit bits still fall in the correct half of the SCL period when the master's phases are ten system clocks long. own_addr is strapped to a 7-bit value for one group of tests and to a 10-bit value whose upper and lower halves can be missed separately. This makes the partial-match abort, the full match and the early reject all reachable in one run.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADR1, ST_ADR2, ST_RECV, ST_XMIT, ST_SKIP
  } tgt_state_e;

  localparam int RA_CTRL = 0;
  localparam int RA_DATA = 1;
  localparam int RA_STAT = 2;

  localparam int SB_IRQ  = 0;
  localparam int SB_ADDR = 1;
  localparam int SB_RXAB = 2;
  localparam int SB_TXAB = 3;
  localparam int SB_OVR  = 4;
  localparam int SB_DIR  = 5;
  localparam int SB_FULL = 6;

  localparam logic [4:0] TEN_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_c,
  output logic stop_c
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p, scl_s;

  // Idle bus is high: reset to 1 so no false edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              ten_mode,
  input  logic [9:0]        own_addr,
  input  logic              go,
  input  logic [BYTE_W-1:0] tx_src,
  output logic              sda_pull,
  output logic              cap_valid,
  output logic [BYTE_W-1:0] cap_byte,
  output logic              cap_addr,
  output logic              cap_abort,
  output logic              tx_taken,
  output logic              tx_done,
  output logic              tx_nack,
  output tgt_state_e        st
);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tgt_state_e        n_st;
  logic [CNT_W-1:0]  cnt, n_cnt;
  logic [BYTE_W-1:0] sh, n_sh, tx_sh, n_tx, rx_byte;
  logic              ack_ok, n_ack, tx_live, n_live, n_pull;
  logic              hi_match, lo_match, a7_match;

  assign rx_byte  = {sh[BYTE_W-2:0], sda_s};
  assign hi_match = (rx_byte[7:3] == TEN_PREFIX) && (rx_byte[2:1] == own_addr[9:8]);
  assign a7_match = rx_byte[7:1] == own_addr[6:0];
  assign lo_match = rx_byte == own_addr[7:0];
  assign cap_byte = rx_byte;

  always_comb begin
    n_st = st; n_cnt = cnt; n_sh = sh; n_ack = ack_ok;
    n_tx = tx_sh; n_live = tx_live; n_pull = sda_pull;
    cap_valid = 1'b0; cap_addr = 1'b0; cap_abort = 1'b0;
    tx_taken = 1'b0; tx_done = 1'b0; tx_nack = 1'b0;
    if (stop_c || start_c) begin
      n_st   = stop_c ? ST_IDLE : ST_ADR1;
      n_cnt  = '0;
      n_ack  = 1'b0;
      n_live = 1'b0;
      n_pull = 1'b0;
    end else if (scl_rise && st != ST_IDLE) begin
      if (cnt != ACK_SLOT) begin
        n_sh  = rx_byte;
        n_cnt = cnt + 1'b1;
        if (cnt == LAST_BIT) begin
          n_ack = 1'b0;
          case (st)
            ST_ADR1: begin
              if (ten_mode ? hi_match : a7_match) begin
                cap_valid = 1'b1;
                cap_addr  = 1'b1;
                n_ack     = 1'b1;
                n_st      = rx_byte[0] ? ST_XMIT : (ten_mode ? ST_ADR2 : ST_RECV);
              end else begin
                n_st = ST_SKIP;
              end
            end
            ST_ADR2: begin
              cap_valid = 1'b1;
              cap_addr  = 1'b1;
              if (lo_match) begin
                n_ack = 1'b1;
                n_st  = ST_RECV;
              end else begin
                cap_abort = 1'b1;
                n_st      = ST_SKIP;
              end
            end
            ST_RECV: begin
              cap_valid = 1'b1;
              n_ack     = 1'b1;
            end
            default: ;
          endcase
        end
      end else begin
        n_cnt = '0;
        if (tx_live) begin
          tx_done = 1'b1;
          tx_nack = sda_s;
          n_live  = 1'b0;
          if (sda_s) n_st = ST_SKIP;
        end
      end
    end else if (scl_fall && st != ST_IDLE) begin
      if (cnt == ACK_SLOT) begin
        n_pull = ack_ok;
      end else if (st == ST_XMIT) begin
        if (cnt == '0) begin
          n_tx     = go ? tx_src : '1;
          tx_taken = go;
          n_live   = 1'b1;
          n_pull   = ~n_tx[BYTE_W-1];
        end else begin
          n_pull = ~tx_sh[IDX_W'(BYTE_W - 1) - cnt[IDX_W-1:0]];
        end
      end else begin
        n_pull = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx_sh    <= '0;
      ack_ok   <= 1'b0;
      tx_live  <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      st       <= n_st;
      cnt      <= n_cnt;
      sh       <= n_sh;
      tx_sh    <= n_tx;
      ack_ok   <= n_ack;
      tx_live  <= n_live;
      sda_pull <= n_pull;
    end
  end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic              cap_valid,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              cap_addr,
  input  logic              cap_abort,
  input  logic              tx_taken,
  input  logic              tx_done,
  input  logic              tx_nack,
  input  logic              dir_tx,
  output logic              go,
  output logic              ten,
  output logic [BYTE_W-1:0] data_q,
  output logic [BYTE_W-1:0] stat_q
);
  logic wr_ctrl, wr_data, wr_stat, rd_data;
  logic irq_q, addr_q, rxab_q, txab_q, ovr_q, full_q;
  logic n_go, n_ten, n_irq, n_addr, n_rxab, n_txab, n_ovr, n_full;
  logic [BYTE_W-1:0] n_data;

  assign wr_ctrl = cpu_en & cpu_we & (cpu_addr == 2'(RA_CTRL));
  assign wr_data = cpu_en & cpu_we & (cpu_addr == 2'(RA_DATA));
  assign wr_stat = cpu_en & cpu_we & (cpu_addr == 2'(RA_STAT));
  assign rd_data = cpu_en & ~cpu_we & (cpu_addr == 2'(RA_DATA));

  always_comb begin
    n_ten  = wr_ctrl ? cpu_wdata[1] : ten;
    n_go   = wr_ctrl ? cpu_wdata[0] : (go & ~tx_taken);
    n_data = cap_valid ? cap_byte : (wr_data ? cpu_wdata : data_q);
    n_addr = cap_valid ? cap_addr : addr_q;
    n_full = cap_valid | (full_q & ~rd_data);
    // Sticky flags: a new event wins over a same-cycle clear.
    n_irq  = (cap_valid | tx_done)   | (irq_q  & ~(wr_stat & cpu_wdata[SB_IRQ]));
    n_rxab = (cap_valid & cap_abort) | (rxab_q & ~(wr_stat & cpu_wdata[SB_RXAB]));
    n_txab = (tx_done & tx_nack)     | (txab_q & ~(wr_stat & cpu_wdata[SB_TXAB]));
    n_ovr  = (cap_valid & full_q)    | (ovr_q  & ~(wr_stat & cpu_wdata[SB_OVR]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0; ten <= 1'b0; data_q <= '0;
      irq_q <= 1'b0; addr_q <= 1'b0; rxab_q <= 1'b0;
      txab_q <= 1'b0; ovr_q <= 1'b0; full_q <= 1'b0;
    end else begin
      go <= n_go; ten <= n_ten; data_q <= n_data;
      irq_q <= n_irq; addr_q <= n_addr; rxab_q <= n_rxab;
      txab_q <= n_txab; ovr_q <= n_ovr; full_q <= n_full;
    end
  end

  always_comb begin
    stat_q          = '0;
    stat_q[SB_IRQ]  = irq_q;
    stat_q[SB_ADDR] = addr_q;
    stat_q[SB_RXAB] = rxab_q;
    stat_q[SB_TXAB] = txab_q;
    stat_q[SB_OVR]  = ovr_q;
    stat_q[SB_DIR]  = dir_tx;
    stat_q[SB_FULL] = full_q;
    case (cpu_addr)
      2'(RA_CTRL): cpu_rdata = {{(BYTE_W-2){1'b0}}, ten, go};
      2'(RA_DATA): cpu_rdata = data_q;
      2'(RA_STAT): cpu_rdata = stat_q;
      default:     cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [9:0]        own_addr,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_q;
  logic scl_rise, scl_fall, sda_s, start_c, stop_c;
  logic cap_valid, cap_addr, cap_abort, tx_taken, tx_done, tx_nack;
  logic go, ten;
  logic [BYTE_W-1:0] cap_byte, data_q, stat_q;
  tgt_state_e st;

  // Asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_c(start_c), .stop_c(stop_c)
  );

  i2c_tgt_engine u_eng (
    .clk(clk), .rst_n(rst_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_c(start_c), .stop_c(stop_c), .ten_mode(ten),
    .own_addr(own_addr), .go(go), .tx_src(data_q), .sda_pull(sda_pull),
    .cap_valid(cap_valid), .cap_byte(cap_byte), .cap_addr(cap_addr),
    .cap_abort(cap_abort), .tx_taken(tx_taken), .tx_done(tx_done),
    .tx_nack(tx_nack), .st(st)
  );

  i2c_tgt_regs u_regs (
    .clk(clk), .rst_n(rst_q), .cpu_en(cpu_en), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cap_valid(cap_valid), .cap_byte(cap_byte), .cap_addr(cap_addr),
    .cap_abort(cap_abort), .tx_taken(tx_taken), .tx_done(tx_done),
    .tx_nack(tx_nack), .dir_tx(st == ST_XMIT), .go(go), .ten(ten),
    .data_q(data_q), .stat_q(stat_q)
  );

  assign irq = stat_q[SB_IRQ];
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic              irq,
  input logic              sda_pull,
  input logic              cap_valid,
  input logic              tx_done,
  input logic              tx_taken,
  input logic              go,
  input logic              ten,
  input logic              stop_c,
  input logic [BYTE_W-1:0] stat_q,
  input tgt_state_e        st
);
  // R9 / R1: the interrupt only rises right after a byte event.
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(irq) |-> $past(cap_valid || tx_done));

  // R7: overrun only when a capture meets an unread byte.
  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(stat_q[SB_OVR]) |-> $past(cap_valid && stat_q[SB_FULL]));

  // R8: a byte is taken from DATA only while GO is set.
  p_go_taken_r8: assert property (@(posedge clk) disable iff (!rst_q)
    tx_taken |-> go);

  // R5: receive abort only appears in 10-bit mode.
  p_abort_mode_r5: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(stat_q[SB_RXAB]) |-> ten);

  // R11: STOP leaves the engine idle with SDA released.
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_q)
    stop_c |=> (st == ST_IDLE) && !sda_pull);

  // R3: no pull on SDA while idle.
  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_IDLE) |-> !sda_pull);
endmodule

bind i2c_tgt_top i2c_tgt_chk u_chk (
  .clk(clk), .rst_q(rst_q), .irq(irq), .sda_pull(sda_pull),
  .cap_valid(cap_valid), .tx_done(tx_done), .tx_taken(tx_taken),
  .go(go), .ten(ten), .stop_c(stop_c), .stat_q(stat_q), .st(st)
);

// File: tb/sim_i2c_tgt_top.sv
`timescale 1ns/1ps
module sim_i2c_tgt_top;
  logic clk, rst_n, scl_m, sda_m, cpu_en, cpu_we;
  logic [1:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [9:0] own_addr;
  logic sda_pull, irq;
  wire  sda_line = sda_m & ~sda_pull;
  int   checks, errors;
  logic done;

  i2c_tgt_top #(.SYNC_STAGES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .own_addr(own_addr), .cpu_en(cpu_en),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_en = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_en = 0; cpu_we = 0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_en = 1; cpu_we = 0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_en = 0;
  endtask

  task automatic half; repeat (10) @(negedge clk); endtask

  task automatic bus_start;
    scl_m = 1; sda_m = 1; half(); sda_m = 0; half();
  endtask
  task automatic bus_rstart;
    scl_m = 0; half(); sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half();
  endtask
  task automatic bus_stop;
    scl_m = 0; half(); sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half();
  endtask

  // Master writes a byte; returns with SCL high in the ack clock.
  task automatic mbyte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      scl_m = 0; half(); sda_m = b[k]; half(); scl_m = 1; half(); half();
    end
    scl_m = 0; half(); sda_m = 1; half(); scl_m = 1; half();
    ack = ~sda_line;
  endtask

  // Master reads a byte and answers with nack; returns with SCL high.
  task automatic sbyte(output logic [7:0] b, input logic nack);
    for (int k = 7; k >= 0; k--) begin
      scl_m = 0; half(); sda_m = 1; half(); scl_m = 1; half();
      b[k] = sda_line; half();
    end
    scl_m = 0; half(); sda_m = nack; half(); scl_m = 1; half();
  endtask

  // {address byte, data byte, expected match}
  localparam logic [16:0] VEC [5] = '{
    {8'hA4, 8'h3C, 1'b1},
    {8'hA6, 8'h77, 1'b0},
    {8'hA4, 8'hFF, 1'b1},
    {8'h24, 8'h81, 1'b0},
    {8'hA4, 8'h00, 1'b1}
  };

  logic       ak;
  logic [7:0] rv, exp_data;

  initial begin
    checks = 0; errors = 0; done = 0;
    scl_m = 1; sda_m = 1; cpu_en = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    own_addr = 10'h052; rst_n = 0;
    repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);

    // R12 reset state
    chk("R12 reset sda_pull", {7'b0, sda_pull}, 8'h00);
    chk("R12 reset irq", {7'b0, irq}, 8'h00);
    cpu_rd(0, rv); chk("R12 reset CTRL", rv, 8'h00);
    cpu_rd(1, rv); chk("R12 reset DATA", rv, 8'h00);
    cpu_rd(2, rv); chk("R12 reset STAT", rv, 8'h00);
    exp_data = 8'h00;

    // R1 R2 R3: 7-bit write table
    for (int i = 0; i < 5; i++) begin
      bus_start();
      mbyte(VEC[i][16:9], ak);
      chk(VEC[i][0] ? "R1 addr ack" : "R3 addr nack", {7'b0, ak}, {7'b0, VEC[i][0]});
      chk(VEC[i][0] ? "R1 addr irq" : "R3 no irq", {7'b0, irq}, {7'b0, VEC[i][0]});
      if (VEC[i][0]) begin
        exp_data = VEC[i][16:9];
        cpu_rd(2, rv); chk("R1 STAT addr bit", {7'b0, rv[1]}, 8'h01);
      end
      cpu_rd(1, rv); chk(VEC[i][0] ? "R1 DATA addr" : "R3 DATA kept", rv, exp_data);
      cpu_wr(2, 8'h1D);
      mbyte(VEC[i][8:1], ak);
      chk(VEC[i][0] ? "R2 data ack" : "R3 data nack", {7'b0, ak}, {7'b0, VEC[i][0]});
      chk(VEC[i][0] ? "R2 data irq" : "R3 data no irq", {7'b0, irq}, {7'b0, VEC[i][0]});
      if (VEC[i][0]) begin
        exp_data = VEC[i][8:1];
        cpu_rd(2, rv); chk("R2 STAT addr bit clear", {7'b0, rv[1]}, 8'h00);
      end
      cpu_rd(1, rv); chk(VEC[i][0] ? "R2 DATA" : "R3 DATA kept", rv, exp_data);
      cpu_wr(2, 8'h1D);
      bus_stop();
      chk("R11 released after stop", {7'b0, sda_pull}, 8'h00);
    end

    // R7 overrun
    bus_start(); mbyte(8'hA4, ak); cpu_rd(1, rv); cpu_wr(2, 8'h1D);
    mbyte(8'h11, ak); cpu_wr(2, 8'h01);
    mbyte(8'h22, ak);
    cpu_rd(2, rv); chk("R7 overrun flag", {7'b0, rv[4]}, 8'h01);
    cpu_rd(1, rv); chk("R7 DATA newest", rv, 8'h22);
    cpu_wr(2, 8'h1D); bus_stop();

    // R11 repeated START after a miss
    bus_start(); mbyte(8'h24, ak); chk("R11 miss before rstart", {7'b0, ak}, 8'h00);
    bus_rstart(); mbyte(8'hA4, ak);
    chk("R11 ack after rstart", {7'b0, ak}, 8'h01);
    chk("R11 irq after rstart", {7'b0, irq}, 8'h01);
    cpu_rd(1, rv); cpu_wr(2, 8'h1D); bus_stop();

    // R8 R9 R10 transmit
    bus_start(); mbyte(8'hA5, ak);
    chk("R8 read addr ack", {7'b0, ak}, 8'h01);
    cpu_rd(1, rv); cpu_wr(2, 8'h1D);
    cpu_wr(1, 8'h96); cpu_wr(0, 8'h01);
    sbyte(rv, 1'b0);
    chk("R8 sent byte", rv, 8'h96);
    chk("R9 tx irq", {7'b0, irq}, 8'h01);
    cpu_rd(0, rv); chk("R8 GO consumed", rv, 8'h00);
    cpu_wr(2, 8'h1D);
    sbyte(rv, 1'b1);
    chk("R8 no GO sends ones", rv, 8'hFF);
    cpu_rd(2, rv); chk("R10 tx abort flag", {7'b0, rv[3]}, 8'h01);
    chk("R9 irq on nacked byte", {7'b0, rv[0]}, 8'h01);
    cpu_wr(2, 8'h1D);
    sbyte(rv, 1'b0);
    chk("R10 released after abort", rv, 8'hFF);
    chk("R10 no irq after abort", {7'b0, irq}, 8'h00);
    bus_stop();

    // R4 R5 R6 10-bit
    own_addr = 10'h2A7; cpu_wr(0, 8'h02);
    bus_start(); mbyte(8'hF4, ak);
    chk("R4 first half ack", {7'b0, ak}, 8'h01);
    chk("R4 first half irq", {7'b0, irq}, 8'h01);
    cpu_rd(1, rv); cpu_wr(2, 8'h1D);
    mbyte(8'hA7, ak);
    chk("R4 second half ack", {7'b0, ak}, 8'h01);
    cpu_rd(2, rv); chk("R4 second half irq+addr", rv[1:0], 8'h03);
    cpu_rd(1, rv); cpu_wr(2, 8'h1D);
    mbyte(8'h5A, ak);
    chk("R4 data after full match", {7'b0, ak}, 8'h01);
    cpu_rd(1, rv); chk("R4 data byte", rv, 8'h5A);
    cpu_wr(2, 8'h1D); bus_stop();

    bus_start(); mbyte(8'hF4, ak); cpu_rd(1, rv); cpu_wr(2, 8'h1D);
    mbyte(8'hA6, ak);
    chk("R5 second half nack", {7'b0, ak}, 8'h00);
    cpu_rd(2, rv); chk("R5 abort+irq", {5'b0, rv[2:0]}, 8'h07);
    cpu_rd(1, rv); cpu_wr(2, 8'h1D);
    mbyte(8'h33, ak);
    chk("R5 rest ignored ack", {7'b0, ak}, 8'h00);
    chk("R5 rest ignored irq", {7'b0, irq}, 8'h00);
    bus_stop();

    bus_start(); mbyte(8'hF6, ak);
    chk("R6 upper mismatch nack", {7'b0, ak}, 8'h00);
    chk("R6 upper mismatch irq", {7'b0, irq}, 8'h00);
    bus_stop();

    done = 1;
    report();
  end
endmodule